// File: doc/BRIEF.md
# Double-Buffered Power-of-Two PWM Timer

This block produces a pulse-width-modulated level from an 8-bit up-counter. The counter advances one step on each prescaler enable tick while the timer runs. Its cycle length is a power of two, 64, 128 or 256 counts, chosen by a 2-bit select. An output flip-flop inverts at two points in each cycle: once when the count reaches a programmed compare value, and once when the count wraps at the end of the cycle. The compare value therefore sets the low time of each cycle, and the cycle length sets the period.

Compare writes can go straight to the live compare register. They can also be held in a shadow register that is copied into the live register only when the counter wraps. With the shadow in use, software can change the duty at any moment without producing a distorted cycle. A separate control pulse forces the output to 0, and an enable gates all inversions. Stopping the timer returns the count to zero, so counting always restarts from the beginning of a cycle.

Top module: `pwm8_dbuf`

## Requirements
- R1: After reset `pwm_out` is 0 and the compare and shadow registers are zero, so a cycle that starts before any compare write gives no match inversion.
- R2: The counter advances only on a clock where both `run` and `tick` are 1. While `run` is 0 the count is held at zero, and counting resumes from zero when `run` returns to 1.
- R3: `len_sel` selects the cycle length: 0 gives 64 counts, 1 gives 128 and 2 gives 256. The reserved code 3 also gives 256.
- R4: On the tick that ends a cycle, the count wraps to zero in that same tick and the output inverts when `inv_en` is 1.
- R5: On the tick that takes the count to the live compare value, the output inverts when `inv_en` is 1.
- R6: A compare value of 0, or one not below the cycle length, produces no match inversion. The output then inverts only at the wrap.
- R7: With `dbuf_en` at 1, a `cmp_wr` pulse stores `cmp_data` in the shadow register and leaves the live compare unchanged. The shadow is copied into the live compare on the wrap tick.
- R8: With `dbuf_en` at 0, a `cmp_wr` pulse loads `cmp_data` into the live compare on the next clock, and that value applies within the current cycle.
- R9: A `ff_clr` pulse forces `pwm_out` to 0 on the next clock. It takes priority over an inversion in the same clock and does not stop counting.
- R10: While `inv_en` is 0 the output holds its level, whatever the count does.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| tick | input | 1 | Count enable pulse from the prescaler |
| run | input | 1 | 1 counts, 0 stops and clears the count |
| len_sel | input | 2 | Cycle length select (0:64, 1:128, 2 or 3:256) |
| cmp_wr | input | 1 | Compare write strobe |
| cmp_data | input | 8 | Compare write data |
| dbuf_en | input | 1 | 1 routes compare writes through the shadow register |
| ff_clr | input | 1 | Forces the output flip-flop to 0 |
| inv_en | input | 1 | Allows match and wrap inversions |
| pwm_out | output | 1 | PWM output level |

## Verification
The hardest case to reach is a shadowed compare write that lands in the middle of a running cycle, after the old match point has already passed and before the wrap. Only then does the difference between buffered and direct loading show at the pin. The stimulus starts a fresh 64-count cycle, writes a new compare value after a known number of ticks, and samples the output at tick counts chosen on either side of the old match point, the new match point and the wrap. A cycle-by-cycle reference model, run alongside, also covers the clocks where a write, a clear or a stop falls on the wrap tick.

// File: rtl/pwm8_dbuf.sv
module pwm8_dbuf #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         tick,
  input  logic         run,
  input  logic [1:0]   len_sel,
  input  logic         cmp_wr,
  input  logic [W-1:0] cmp_data,
  input  logic         dbuf_en,
  input  logic         ff_clr,
  input  logic         inv_en,
  output logic         pwm_out
);

  localparam logic [W-1:0] ONE   = {{(W-1){1'b0}}, 1'b1};
  localparam logic [W-1:0] LIM_S = {2'b00, {(W-2){1'b1}}};
  localparam logic [W-1:0] LIM_M = {1'b0, {(W-1){1'b1}}};
  localparam logic [W-1:0] LIM_L = {W{1'b1}};

  logic [W-1:0] cnt, cmp, shadow, lim;
  logic         step, ovf, hit, ff;

  always_comb begin
    case (len_sel)
      2'd0:    lim = LIM_S;
      2'd1:    lim = LIM_M;
      default: lim = LIM_L;
    endcase
  end

  assign step = run & tick;
  assign ovf  = step & ((cnt & lim) == lim);
  assign hit  = step & ~ovf & (cmp != '0) & ((cmp & ~lim) == '0) & ((cnt + ONE) == cmp);

  always_ff @(posedge clk) begin
    if (!rst_n)      cnt <= '0;
    else if (!run)   cnt <= '0;
    else if (ovf)    cnt <= '0;
    else if (step)   cnt <= cnt + ONE;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cmp    <= '0;
      shadow <= '0;
    end else if (dbuf_en) begin
      if (ovf)    cmp    <= shadow;
      if (cmp_wr) shadow <= cmp_data;
    end else if (cmp_wr) begin
      cmp <= cmp_data;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)                    ff <= 1'b0;
    else if (ff_clr)               ff <= 1'b0;
    else if (inv_en & (hit | ovf)) ff <= ~ff;
  end

  assign pwm_out = ff;

endmodule

module pwm8_dbuf_chk #(
  parameter int W = 8
) (
  input logic         clk,
  input logic         rst_n,
  input logic         tick,
  input logic         run,
  input logic         cmp_wr,
  input logic [W-1:0] cmp_data,
  input logic         dbuf_en,
  input logic         ff_clr,
  input logic         inv_en,
  input logic [W-1:0] cnt,
  input logic [W-1:0] cmp,
  input logic [W-1:0] shadow,
  input logic         ovf,
  input logic         pwm_out
);

  // R2
  stop_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !run |=> cnt == '0);

  // R2
  no_tick_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (run && !tick) |=> $stable(cnt));

  // R4
  wrap_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ovf |=> cnt == '0);

  // R7
  shadow_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (dbuf_en && !ovf) |=> $stable(cmp));

  // R7
  shadow_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (dbuf_en && ovf) |=> cmp == $past(shadow));

  // R8
  direct_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!dbuf_en && cmp_wr) |=> cmp == $past(cmp_data));

  // R9
  ff_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ff_clr |=> !pwm_out);

  // R10
  no_inv_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!inv_en && !ff_clr) |=> $stable(pwm_out));

endmodule

bind pwm8_dbuf pwm8_dbuf_chk #(.W(W)) u_chk (
  .clk(clk), .rst_n(rst_n), .tick(tick), .run(run), .cmp_wr(cmp_wr),
  .cmp_data(cmp_data), .dbuf_en(dbuf_en), .ff_clr(ff_clr), .inv_en(inv_en),
  .cnt(cnt), .cmp(cmp), .shadow(shadow), .ovf(ovf), .pwm_out(pwm_out)
);

// File: tb/sim_pwm8_dbuf.sv
module sim_pwm8_dbuf;
  logic clk = 1'b0, rst_n = 1'b0, tick = 1'b1, run = 1'b0;
  logic [1:0] len_sel = 2'd0;
  logic cmp_wr = 1'b0, dbuf_en = 1'b0, ff_clr = 1'b0, inv_en = 1'b0;
  logic [7:0] cmp_data = 8'd0;
  logic pwm_out;

  int n_cmp = 0, n_bad = 0, cyc = 0;
  bit half = 1'b0, live = 1'b0, done = 1'b0;
  string tag = "R1";

  int m_cnt = 0, m_cmp = 0, m_buf = 0;
  bit m_ff = 1'b0;

  always #2.5 clk = ~clk;

  pwm8_dbuf u0 (.clk(clk), .rst_n(rst_n), .tick(tick), .run(run), .len_sel(len_sel),
    .cmp_wr(cmp_wr), .cmp_data(cmp_data), .dbuf_en(dbuf_en), .ff_clr(ff_clr),
    .inv_en(inv_en), .pwm_out(pwm_out));

  always @(negedge clk) tick <= half ? ~tick : 1'b1;

  always @(posedge clk) begin
    int per;
    bit ov, mt;
    per = (len_sel == 2'd0) ? 64 : (len_sel == 2'd1) ? 128 : 256;
    if (!rst_n) begin
      m_cnt = 0; m_cmp = 0; m_buf = 0; m_ff = 0;
    end else begin
      ov = run && tick && (m_cnt % per == per - 1);
      mt = run && tick && !ov && m_cmp != 0 && m_cmp < per && m_cnt + 1 == m_cmp;
      if (ff_clr) m_ff = 0;
      else if (inv_en && (ov || mt)) m_ff = !m_ff;
      if (dbuf_en) begin
        if (ov) m_cmp = m_buf;
        if (cmp_wr) m_buf = cmp_data;
      end else if (cmp_wr) m_cmp = cmp_data;
      if (!run || ov) m_cnt = 0;
      else if (tick) m_cnt = m_cnt + 1;
    end
  end

  task automatic chk(bit ok, string r, int act, int exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", r, act, exp);
    end
  endtask

  always @(negedge clk) if (live && rst_n) chk(pwm_out == m_ff, tag, pwm_out, m_ff);

  task automatic step(int k);
    repeat (k) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic prep(logic [1:0] len, logic [7:0] v);
    run = 0; ff_clr = 1; dbuf_en = 0; cmp_wr = 1; cmp_data = v; len_sel = len;
    step(1);
    ff_clr = 0; cmp_wr = 0; inv_en = 1; run = 1;
  endtask

  task automatic toggles(int nclk, string r, int exp);
    int t = 0;
    bit p = pwm_out;
    for (int i = 0; i < nclk; i++) begin
      step(1);
      if (pwm_out != p) t++;
      p = pwm_out;
    end
    chk(t == exp, r, t, exp);
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000 && !done) begin
      done = 1;
      n_cmp++; n_bad++;
      $display("FAIL watchdog: actual %0d expected below 150000", cyc);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    step(3);
    rst_n = 1; live = 1;
    step(1);
    chk(pwm_out == 0, "R1", pwm_out, 0);
    tag = "R1"; run = 1; inv_en = 1; len_sel = 2'd2;
    toggles(260, "R1", 1);

    tag = "R3"; prep(2'd0, 8'd16); toggles(260, "R3", 8);
    prep(2'd1, 8'd16); toggles(260, "R3", 4);
    tag = "R6"; prep(2'd3, 8'd0); toggles(260, "R3", 1);
    prep(2'd0, 8'd200); toggles(260, "R6", 4);
    tag = "R5"; prep(2'd2, 8'd100); toggles(260, "R5", 2);

    tag = "R2"; half = 1; prep(2'd0, 8'd16); toggles(260, "R2", 4);
    half = 0;
    prep(2'd0, 8'd16); step(40); run = 0; step(10);
    chk(pwm_out == 1, "R2", pwm_out, 1);
    run = 1; step(15); chk(pwm_out == 1, "R2", pwm_out, 1);
    step(2); chk(pwm_out == 0, "R2", pwm_out, 0);

    tag = "R7"; prep(2'd0, 8'd16); dbuf_en = 1; step(20);
    cmp_wr = 1; cmp_data = 8'd40; step(1); cmp_wr = 0; step(29);
    chk(pwm_out == 1, "R7", pwm_out, 1);
    step(44); chk(pwm_out == 0, "R7", pwm_out, 0);
    step(16); chk(pwm_out == 1, "R7", pwm_out, 1);

    tag = "R8"; prep(2'd0, 8'd16); step(20);
    cmp_wr = 1; cmp_data = 8'd40; step(1); cmp_wr = 0; step(29);
    chk(pwm_out == 0, "R8", pwm_out, 0);
    step(14); chk(pwm_out == 1, "R8", pwm_out, 1);

    tag = "R9"; prep(2'd0, 8'd16); step(20);
    chk(pwm_out == 1, "R9", pwm_out, 1);
    ff_clr = 1; step(1); ff_clr = 0;
    chk(pwm_out == 0, "R9", pwm_out, 0);
    step(42); chk(pwm_out == 0, "R9", pwm_out, 0);
    step(1); chk(pwm_out == 1, "R9", pwm_out, 1);
    prep(2'd0, 8'd16); step(15); ff_clr = 1; step(1); ff_clr = 0;
    chk(pwm_out == 0, "R9", pwm_out, 0);

    tag = "R10"; prep(2'd0, 8'd16); inv_en = 0; toggles(260, "R10", 0);
    tag = "R4"; inv_en = 1; prep(2'd0, 8'd0); toggles(130, "R4", 2);

    step(2);
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule